// File: doc/BRIEF.md
# Dual-Channel Threshold Alarm Monitor

This block watches a stream of digitised measurements for two channels, each channel carrying a temperature reading and a current reading. Every sample arrives with a valid strobe, a channel number, a kind bit and a 12-bit value. Each of the four measurement sources has its own high and low limits, its own enable bit and its own choice of comparison style. A per-source fault flag is maintained, and the flags are gathered into one safe-state output per channel and one shared alarm output.

Each source runs a two-state machine with states CLEAR and FAULT. It has four transitions. SET goes from CLEAR to FAULT when a matching sample is out of band. RELEASE goes from FAULT to CLEAR when a matching sample meets the clear condition. HOLD keeps the present state on any cycle without a qualifying sample. DISABLE forces the state to CLEAR on any cycle in which the source's enable is low.

Two comparison styles are available. In the hysteresis style, the high limit sets the flag and the low limit releases it. In the window style, leaving the range sets the flag and re-entering it by a programmable margin releases it. A separate alarm option replaces the latched alarm with the raw result of the latest comparison, and it leaves the safe outputs alone.

Top module: `dual_alarm_monitor`

## Requirements
- R1: Source index is `{smp_chan, smp_kind}`, giving 0 = channel 1 temperature, 1 = channel 1 current, 2 = channel 2 temperature and 3 = channel 2 current (kind 0 = temperature, 1 = current). A sample updates only the flag of its own source. With no valid sample, every flag holds.
- R2: Hysteresis style (`src_win` bit = 0): the flag sets when value > high limit. A value equal to the high limit does not set it.
- R3: Hysteresis style: a set flag releases only when value < low limit. A value equal to the low limit, or any larger value, keeps it set.
- R4: Window style (`src_win` bit = 1): the flag sets when value < low limit or value > high limit.
- R5: Window style: a set flag releases only when low + H ≤ value ≤ high − H. Otherwise it holds. `hyst_sel` 0, 1, 2 and 3 give H = 0, 4, 8 and 16 LSBs.
- R6: A source whose `src_en` bit is 0 has its flag forced clear and affects no output. When re-enabled, it starts from the clear state.
- R7: `safe[0]` is the OR of the enabled flags of sources 0 and 1. `safe[1]` is the OR of the enabled flags of sources 2 and 3. A channel's sources never touch the other channel's output.
- R8: With `alarm_direct` = 0, `alarm` is the OR of all enabled flags.
- R9: With `alarm_direct` = 1, `alarm` is the out-of-band result of the most recent valid sample from an enabled source, with no latching. Out of band means value > high in hysteresis style, and outside the range in window style. Samples from disabled sources leave it unchanged. Changing `alarm_direct` never changes `safe`.
- R10: All flags and outputs are 0 after reset. A sample captured at clock edge k changes the flag at edge k and changes `safe`/`alarm` at edge k+1, but not at edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe, one cycle per sample |
| smp_chan | input | CH_W (1) | Channel number, 0 = channel 1 |
| smp_kind | input | 1 | 0 = temperature, 1 = current |
| smp_value | input | DATA_W (12) | Sample value, unsigned |
| thr_hi | input | NSRC*DATA_W (48) | High limits, source i in bits [i*DATA_W +: DATA_W] |
| thr_lo | input | NSRC*DATA_W (48) | Low limits, same packing |
| src_en | input | NSRC (4) | Per-source enable |
| src_win | input | NSRC (4) | Per-source style, 0 = hysteresis, 1 = window |
| hyst_sel | input | 2 | Window release margin code |
| alarm_direct | input | 1 | 1 = alarm follows latest raw comparison |
| safe | output | NUM_CH (2) | Per-channel safe-state request |
| alarm | output | 1 | Shared alarm |

## Verification
The bench builds the block with its defaults: DATA_W = 12, NUM_CH = 2 and HYST_UNIT = 4. These bring the full value range 0 to 4095 into reach, along with all four sources and both safe outputs. The largest margin code gives a 16-LSB release band, so it can be probed one LSB on either side of each edge. Using two channels exercises the cross-channel isolation and the merge into the shared alarm. Using both styles on different sources at once shows that the mode bits act per source.

// File: rtl/alarm_mon_pkg.sv
package alarm_mon_pkg;

    // Per-source fault flag state
    typedef enum logic {
        S_CLEAR = 1'b0,
        S_FAULT = 1'b1
    } flag_state_e;

    // Window release margin in LSBs for a given code
    function automatic int unsigned margin_lsbs(input logic [1:0] code, input int unsigned unit);
        case (code)
            2'd0:    return 0;
            2'd1:    return unit;
            2'd2:    return 2 * unit;
            default: return 4 * unit;
        endcase
    endfunction

endpackage

// File: rtl/sample_route.sv
module sample_route #(
    parameter int NUM_CH = 2,
    parameter int CH_W   = 1,
    localparam int NSRC  = 2 * NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [CH_W-1:0]   chan,
    input  logic              kind,
    output logic [NSRC-1:0]   hit
);

    // Source i takes channel i/2 and kind i%2
    for (genvar i = 0; i < NSRC; i++) begin : g_hit
        assign hit[i] = valid && (chan == CH_W'(i / 2)) && (kind == 1'(i % 2));
    end

    // R1: at most one source is addressed per cycle
    assert_onehot_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

    // R1: no strobe means no source is addressed
    assert_no_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (hit == '0));

endmodule

// File: rtl/src_flag_fsm.sv
module src_flag_fsm
    import alarm_mon_pkg::*;
#(
    parameter int DATA_W = 12,
    localparam int EW    = DATA_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              hit,
    input  logic              win,
    input  logic [EW-1:0]     margin,
    input  logic [DATA_W-1:0] value,
    input  logic [DATA_W-1:0] hi,
    input  logic [DATA_W-1:0] lo,
    output logic              fault,
    output logic              oob
);

    flag_state_e st, st_nxt;

    logic [EW-1:0] v_e, hi_e, lo_e;
    logic          above, below, in_band, release_ok;

    assign v_e  = EW'(value);
    assign hi_e = EW'(hi);
    assign lo_e = EW'(lo);

    // Comparisons
    always_comb begin
        above      = v_e > hi_e;
        below      = v_e < lo_e;
        in_band    = (v_e >= lo_e + margin) && (v_e + margin <= hi_e);
        oob        = win ? (above || below) : above;
        release_ok = win ? in_band : below;
    end

    // Next-state: SET, RELEASE, HOLD, DISABLE
    always_comb begin
        st_nxt = st;
        unique case (st)
            S_CLEAR: begin
                if (!en)
                    st_nxt = S_CLEAR;
                else if (hit && oob)
                    st_nxt = S_FAULT;
            end
            S_FAULT: begin
                if (!en)
                    st_nxt = S_CLEAR;
                else if (hit && release_ok)
                    st_nxt = S_CLEAR;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= S_CLEAR;
        else
            st <= st_nxt;
    end

    // Output process
    always_comb begin
        fault = (st == S_FAULT);
    end

    // R2: value at or below high limit never sets in hysteresis style
    assert_hyst_no_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && hit && !win && st == S_CLEAR && value <= hi) |=> (st == S_CLEAR));

    // R3: value at or above low limit keeps a set flag in hysteresis style
    assert_hyst_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && hit && !win && st == S_FAULT && value >= lo) |=> (st == S_FAULT));

    // R4: out-of-range sample in window style leaves the flag set
    assert_win_out_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && hit && win && (value < lo || value > hi)) |=> (st == S_FAULT));

    // R6: disabled source is clear on the next cycle
    assert_disabled_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (st == S_CLEAR));

    // R1: without a matching sample an enabled flag holds
    assert_no_hit_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !hit) |=> $stable(st));

endmodule

// File: rtl/alarm_merge.sv
module alarm_merge #(
    parameter int NUM_CH = 2,
    localparam int NSRC  = 2 * NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   flags,
    input  logic [NSRC-1:0]   en,
    input  logic [NSRC-1:0]   hit,
    input  logic [NSRC-1:0]   oob,
    input  logic              alarm_direct,
    output logic [NUM_CH-1:0] safe,
    output logic              alarm
);

    logic [NSRC-1:0]   masked;
    logic [NUM_CH-1:0] safe_nxt;
    logic              live_hit, live_raw, last_cmp, alarm_nxt;

    assign masked   = flags & en;
    assign live_hit = |(hit & en);
    assign live_raw = |(hit & en & oob);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign safe_nxt[c] = |masked[2*c +: 2];

        // R7: a channel with no enabled flags drops its safe output
        assert_safe_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (masked[2*c +: 2] == 2'b00) |=> !safe[c]);
    end

    assign alarm_nxt = alarm_direct ? last_cmp : (|masked);

    // Latest raw comparison from an enabled source
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_cmp <= 1'b0;
        else if (live_hit)
            last_cmp <= live_raw;
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            safe  <= '0;
            alarm <= 1'b0;
        end else begin
            safe  <= safe_nxt;
            alarm <= alarm_nxt;
        end
    end

    // R9: safe outputs follow only the flags, never the alarm option
    assert_safe_cmp_indep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(masked) |=> $stable(safe));

    // R8: latched alarm is low when no enabled flag is set
    assert_latched_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_direct && masked == '0) |=> !alarm);

    // R8: latched alarm is high when any enabled flag is set
    assert_latched_any_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_direct && masked != '0) |=> alarm);

endmodule

// File: rtl/dual_alarm_monitor.sv
module dual_alarm_monitor
    import alarm_mon_pkg::*;
#(
    parameter int DATA_W    = 12,
    parameter int NUM_CH    = 2,
    parameter int HYST_UNIT = 4,
    localparam int NSRC     = 2 * NUM_CH,
    localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   smp_valid,
    input  logic [CH_W-1:0]        smp_chan,
    input  logic                   smp_kind,
    input  logic [DATA_W-1:0]      smp_value,
    input  logic [NSRC*DATA_W-1:0] thr_hi,
    input  logic [NSRC*DATA_W-1:0] thr_lo,
    input  logic [NSRC-1:0]        src_en,
    input  logic [NSRC-1:0]        src_win,
    input  logic [1:0]             hyst_sel,
    input  logic                   alarm_direct,
    output logic [NUM_CH-1:0]      safe,
    output logic                   alarm
);

    localparam int EW = DATA_W + 2;

    logic [NSRC-1:0] hit, flags, oob;
    logic [EW-1:0]   margin;

    assign margin = EW'(margin_lsbs(hyst_sel, HYST_UNIT));

    sample_route #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) u_route (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (smp_valid),
        .chan  (smp_chan),
        .kind  (smp_kind),
        .hit   (hit)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        src_flag_fsm #(
            .DATA_W (DATA_W)
        ) u_fsm (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (src_en[i]),
            .hit    (hit[i]),
            .win    (src_win[i]),
            .margin (margin),
            .value  (smp_value),
            .hi     (thr_hi[i*DATA_W +: DATA_W]),
            .lo     (thr_lo[i*DATA_W +: DATA_W]),
            .fault  (flags[i]),
            .oob    (oob[i])
        );
    end

    alarm_merge #(
        .NUM_CH (NUM_CH)
    ) u_merge (
        .clk          (clk),
        .rst_n        (rst_n),
        .flags        (flags),
        .en           (src_en),
        .hit          (hit),
        .oob          (oob),
        .alarm_direct (alarm_direct),
        .safe         (safe),
        .alarm        (alarm)
    );

    // R10: outputs are quiet in the cycle after reset
    assert_reset_quiet_R10: assert property (@(posedge clk)
        !rst_n |=> (safe == '0 && !alarm));

endmodule

// File: tb/sim_dual_alarm_monitor.sv
`timescale 1ns/1ps
module sim_dual_alarm_monitor;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        smp_valid;
    logic [0:0]  smp_chan;
    logic        smp_kind;
    logic [11:0] smp_value;
    logic [47:0] thr_hi, thr_lo;
    logic [3:0]  src_en, src_win;
    logic [1:0]  hyst_sel;
    logic        alarm_direct;
    logic [1:0]  safe;
    logic        alarm;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dual_alarm_monitor u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .smp_valid    (smp_valid),
        .smp_chan     (smp_chan),
        .smp_kind     (smp_kind),
        .smp_value    (smp_value),
        .thr_hi       (thr_hi),
        .thr_lo       (thr_lo),
        .src_en       (src_en),
        .src_win      (src_win),
        .hyst_sel     (hyst_sel),
        .alarm_direct (alarm_direct),
        .safe         (safe),
        .alarm        (alarm)
    );

    // {chan, kind, value, expected safe, expected alarm}
    // sources: 0,1 hysteresis; 2,3 window with margin 4
    localparam logic [16:0] TBL [0:16] = '{
        {1'b0, 1'b0, 12'd2000, 2'b00, 1'b0},  // R2 equal to high: no set
        {1'b0, 1'b0, 12'd2001, 2'b01, 1'b1},  // R2 above high: set
        {1'b0, 1'b0, 12'd1000, 2'b01, 1'b1},  // R3 equal to low: hold
        {1'b0, 1'b1, 12'd3001, 2'b01, 1'b1},  // R1 ch1 current sets
        {1'b0, 1'b0, 12'd999,  2'b01, 1'b1},  // R3 ch1 temp releases, current holds
        {1'b0, 1'b1, 12'd499,  2'b00, 1'b0},  // R3 ch1 current releases
        {1'b1, 1'b0, 12'd1199, 2'b10, 1'b1},  // R4 below low sets, R7 only safe[1]
        {1'b1, 1'b0, 12'd1203, 2'b10, 1'b1},  // R5 inside, short of margin: hold
        {1'b1, 1'b0, 12'd1204, 2'b00, 1'b0},  // R5 low+4: release
        {1'b1, 1'b0, 12'd1501, 2'b10, 1'b1},  // R4 above high sets
        {1'b1, 1'b0, 12'd1497, 2'b10, 1'b1},  // R5 high-3: hold
        {1'b1, 1'b0, 12'd1496, 2'b00, 1'b0},  // R5 high-4: release
        {1'b1, 1'b1, 12'd3600, 2'b10, 1'b1},  // R4 ch2 current above high
        {1'b0, 1'b1, 12'd3100, 2'b11, 1'b1},  // R7 both channels set
        {1'b1, 1'b1, 12'd50,   2'b11, 1'b1},  // R4 out below, still set
        {1'b1, 1'b1, 12'd2000, 2'b01, 1'b1},  // R7 ch2 clears, ch1 stays
        {1'b0, 1'b1, 12'd0,    2'b00, 1'b0}   // R8 nothing set: alarm low
    };

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Drive one sample; returns after output edge k+1
    task automatic send(input logic ch, input logic kd, input logic [11:0] v);
        @(negedge clk);
        smp_valid = 1'b1; smp_chan = ch; smp_kind = kd; smp_value = v;
        @(negedge clk);
        smp_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #500000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; smp_valid = 1'b0; smp_chan = '0; smp_kind = 1'b0; smp_value = '0;
        thr_hi = {12'd3500, 12'd1500, 12'd3000, 12'd2000};
        thr_lo = {12'd100,  12'd1200, 12'd500,  12'd1000};
        src_en = 4'b1111; src_win = 4'b1100; hyst_sel = 2'd1; alarm_direct = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 reset safe", safe, 2'b00);
        check("R10 reset alarm", {1'b0, alarm}, 2'b00);

        for (int i = 0; i < 17; i++) begin
            send(TBL[i][16], TBL[i][15], TBL[i][14:3]);
            check($sformatf("R1 vec%0d safe", i), safe, TBL[i][2:1]);
            check($sformatf("R8 vec%0d alarm", i), {1'b0, alarm}, {1'b0, TBL[i][0]});
        end

        // R10: output lags the flag by one edge
        @(negedge clk);
        smp_valid = 1'b1; smp_chan = 1'b0; smp_kind = 1'b0; smp_value = 12'd2500;
        @(negedge clk);
        smp_valid = 1'b0;
        check("R10 no change at edge k", safe, 2'b00);
        @(negedge clk);
        check("R10 change at edge k+1", safe, 2'b01);
        send(1'b0, 1'b0, 12'd0);

        // R2/R3 range extremes
        send(1'b0, 1'b0, 12'd4095);
        check("R2 full-scale sets", safe, 2'b01);
        send(1'b0, 1'b0, 12'd0);
        check("R3 zero releases", safe, 2'b00);

        // R5 margin codes on channel 2 temperature
        hyst_sel = 2'd3;
        send(1'b1, 1'b0, 12'd1199);
        send(1'b1, 1'b0, 12'd1215);
        check("R5 code3 low+15 holds", safe, 2'b10);
        send(1'b1, 1'b0, 12'd1216);
        check("R5 code3 low+16 releases", safe, 2'b00);
        hyst_sel = 2'd2;
        send(1'b1, 1'b0, 12'd1501);
        send(1'b1, 1'b0, 12'd1493);
        check("R5 code2 high-7 holds", safe, 2'b10);
        send(1'b1, 1'b0, 12'd1492);
        check("R5 code2 high-8 releases", safe, 2'b00);
        hyst_sel = 2'd0;
        send(1'b1, 1'b0, 12'd1199);
        send(1'b1, 1'b0, 12'd1200);
        check("R5 code0 low releases", safe, 2'b00);

        // R6: disabled source
        src_en = 4'b1110;
        send(1'b0, 1'b0, 12'd4000);
        check("R6 disabled no safe", safe, 2'b00);
        check("R6 disabled no alarm", {1'b0, alarm}, 2'b00);
        src_en = 4'b1111;
        send(1'b0, 1'b0, 12'd2500);
        check("R6 enabled sets", safe, 2'b01);
        @(negedge clk); src_en = 4'b1110;
        @(negedge clk); @(negedge clk);
        check("R6 disable drops safe", safe, 2'b00);
        check("R6 disable drops alarm", {1'b0, alarm}, 2'b00);
        src_en = 4'b1111;
        send(1'b0, 1'b0, 12'd1500);
        check("R6 re-enabled starts clear", safe, 2'b00);

        // R9: direct alarm option
        alarm_direct = 1'b1;
        send(1'b0, 1'b1, 12'd3100);
        check("R9 direct raw high", {1'b0, alarm}, 2'b01);
        send(1'b0, 1'b0, 12'd1500);
        check("R9 direct raw low", {1'b0, alarm}, 2'b00);
        check("R9 safe keeps latched", safe, 2'b01);
        @(negedge clk); alarm_direct = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R9 back to latched alarm", {1'b0, alarm}, 2'b01);
        check("R9 toggle leaves safe", safe, 2'b01);
        alarm_direct = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R9 toggle again safe", safe, 2'b01);
        src_en = 4'b0111;
        send(1'b1, 1'b1, 12'd4000);
        check("R9 disabled sample ignored", {1'b0, alarm}, 2'b00);
        check("R7 disabled ch2 safe", safe, 2'b01);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule